// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a CPU-side register port and a NAND bus sequencer. A CPU access of one, two or four bytes is broken into a series of device-width bus cycles ("beats") for either an 8-bit or a 16-bit NAND device. Lanes are ordered little-endian: the least significant part goes out first. The block drives the command-latch and address-latch strobes of each beat from the port the CPU addressed. Read beats are packed back into their byte lanes before the CPU sees completion.

The CPU raises `cpu_req` and holds it and the request fields steady until `cpu_ready` pulses. Each beat is offered on `nand_valid` and is held until the sequencer accepts it with `nand_ready`. In that same cycle the sequencer supplies `nand_rdata` for reads. Width and NAND-type configuration are taken when the request is accepted. Bus timing, ECC and chip-select decoding belong to other blocks.

Top module: `nand_width_adapter`

## Requirements
- R1: With an 8-bit device (`cfg_wide`=0), size codes 0, 1 and 2 (1, 2 and 4 bytes) produce 1, 2 and 4 beats. Beat i carries write byte i in `nand_wdata[7:0]`, with bits 15:8 zero.
- R2: With a 16-bit device (`cfg_wide`=1), a 2-byte access is one beat carrying `cpu_wdata[15:0]`. A 4-byte access is two beats: bits 15:0 first, then bits 31:16.
- R3: A byte read from a 16-bit device uses one beat and returns only `nand_rdata[7:0]`, with all upper bits of `cpu_rdata` zero.
- R4: A byte write to a 16-bit device uses one 16-bit beat carrying `cpu_wdata[15:0]`.
- R5: Reads gather the bytes or halfwords of each beat into their little-endian lanes of `cpu_rdata`. Lanes beyond the access size read as zero.
- R6: Port codes are 0 command, 1 address, 2 data and 3 reserved. Command beats raise `nand_cle`, address beats raise `nand_ale`, and data beats raise neither. Both strobes are low whenever `nand_valid` is low.
- R7: An access produces no beat, completes one cycle after acceptance and returns zero read data in any of these cases: `cfg_is_nand` is low, the port is reserved, or the access is a read of the command or address port.
- R8: Size code 3 behaves as a 4-byte access.
- R9: While `nand_valid` is high and `nand_ready` is low, `nand_valid`, `nand_wdata`, `nand_we` and both strobes stay unchanged.
- R10: `cpu_ready` is a one-cycle pulse. It comes one cycle after the last accepted beat, with `cpu_rdata` valid during it. A change of `cfg_wide` after acceptance has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_port | input | 2 | 0 command, 1 address, 2 data, 3 reserved |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Assembled read data, valid with `cpu_ready` |
| cfg_is_nand | input | 1 | Chip select configured as NAND type |
| cfg_wide | input | 1 | 1 for 16-bit device, 0 for 8-bit |
| nand_valid | output | 1 | Beat offered |
| nand_ready | input | 1 | Beat accepted |
| nand_we | output | 1 | Beat direction, 1 write |
| nand_cle | output | 1 | Command-latch strobe for the beat |
| nand_ale | output | 1 | Address-latch strobe for the beat |
| nand_wdata | output | 16 | Beat write data |
| nand_rdata | input | 16 | Beat read data, sampled with `nand_ready` |

## Verification
The embedded assertions rely on the CPU holding `cpu_req` and its fields steady from the request until the `cpu_ready` pulse, and on `cpu_req` being low in the cycle after that pulse. They also rely on `nand_rdata` being meaningful whenever `nand_ready` is high. The stimulus respects all of this: every input changes on the falling edge, and `cpu_req` is dropped on the same falling edge where the `cpu_ready` pulse is seen. Accept stalls come from a shift-register pattern, so beats are held for varying lengths of time. In one access `cfg_wide` is toggled after acceptance, which is a legal change, to exercise R10.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_ADDR = 2'd1,
        PORT_DATA = 2'd2,
        PORT_RSVD = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/nwa_beat_plan.sv
module nwa_beat_plan
    import nwa_pkg::*;
#(
    parameter int CPU_BYTES = 4,
    parameter int CNT_W     = $clog2(CPU_BYTES) + 1
) (
    input  logic [1:0]       size,
    input  logic             wide,
    input  logic             is_nand,
    input  logic             we,
    input  port_e            port,
    output logic [CNT_W-1:0] beats,
    output logic             active
);
    localparam int MAX_CODE = $clog2(CPU_BYTES);

    logic [CNT_W-1:0] nbytes;

    always_comb begin
        if (int'(size) >= MAX_CODE) begin
            nbytes = CNT_W'(CPU_BYTES);
        end else begin
            nbytes = CNT_W'(1) << size;
        end
        beats  = wide ? ((nbytes + CNT_W'(1)) >> 1) : nbytes;
        active = is_nand &&
                 ((port == PORT_DATA) ||
                  (we && ((port == PORT_CMD) || (port == PORT_ADDR))));
    end
endmodule

// File: rtl/nwa_lane_mux.sv
module nwa_lane_mux #(
    parameter int CPU_BYTES = 4,
    parameter int IDX_W     = $clog2(CPU_BYTES)
) (
    input  logic [8*CPU_BYTES-1:0] wdata,
    input  logic [8*CPU_BYTES-1:0] rd_acc,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   wide,
    input  logic                   byte_only,
    input  logic [15:0]            dev_rdata,
    output logic [15:0]            beat_wdata,
    output logic [8*CPU_BYTES-1:0] rd_next
);
    localparam int HALVES = CPU_BYTES / 2;

    logic [CPU_BYTES-1:0][7:0] wb;
    logic [CPU_BYTES-1:0][7:0] rb;
    logic [HALVES-1:0][15:0]   wh;
    logic [IDX_W-2:0]          hidx;

    assign wb   = wdata;
    assign wh   = wdata;
    assign hidx = idx[IDX_W-2:0];

    always_comb begin
        beat_wdata = wide ? wh[hidx] : {8'h00, wb[idx]};
        rb = rd_acc;
        if (wide) begin
            rb[{hidx, 1'b0}] = dev_rdata[7:0];
            if (!byte_only) begin
                rb[{hidx, 1'b1}] = dev_rdata[15:8];
            end
        end else begin
            rb[idx] = dev_rdata[7:0];
        end
        rd_next = rb;
    end
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
    import nwa_pkg::*;
#(
    parameter int CPU_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic [1:0]             cpu_port,
    input  logic [1:0]             cpu_size,
    input  logic                   cpu_we,
    input  logic [8*CPU_BYTES-1:0] cpu_wdata,
    output logic                   cpu_ready,
    output logic [8*CPU_BYTES-1:0] cpu_rdata,
    input  logic                   cfg_is_nand,
    input  logic                   cfg_wide,
    output logic                   nand_valid,
    input  logic                   nand_ready,
    output logic                   nand_we,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic [15:0]            nand_wdata,
    input  logic [15:0]            nand_rdata
);
    localparam int CPU_W = 8 * CPU_BYTES;
    localparam int IDX_W = $clog2(CPU_BYTES);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        state_e           st;
        port_e            port;
        logic             we;
        logic             wide;
        logic             byte_only;
        logic [CNT_W-1:0] beats;
        logic [IDX_W-1:0] idx;
        logic [CPU_W-1:0] wdata;
        logic [CPU_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0] plan_beats;
    logic             plan_active;
    logic [CPU_W-1:0] rd_next;
    logic [15:0]      beat_wdata;

    nwa_beat_plan #(.CPU_BYTES(CPU_BYTES), .CNT_W(CNT_W)) plan_i (
        .size    (cpu_size),
        .wide    (cfg_wide),
        .is_nand (cfg_is_nand),
        .we      (cpu_we),
        .port    (port_e'(cpu_port)),
        .beats   (plan_beats),
        .active  (plan_active)
    );

    nwa_lane_mux #(.CPU_BYTES(CPU_BYTES), .IDX_W(IDX_W)) lane_i (
        .wdata      (r_q.wdata),
        .rd_acc     (r_q.rdata),
        .idx        (r_q.idx),
        .wide       (r_q.wide),
        .byte_only  (r_q.byte_only),
        .dev_rdata  (nand_rdata),
        .beat_wdata (beat_wdata),
        .rd_next    (rd_next)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.port      = port_e'(cpu_port);
                    r_d.we        = cpu_we;
                    r_d.wide      = cfg_wide;
                    r_d.byte_only = (cpu_size == 2'd0);
                    r_d.beats     = plan_beats;
                    r_d.idx       = '0;
                    r_d.wdata     = cpu_wdata;
                    r_d.rdata     = '0;
                    r_d.st        = plan_active ? ST_RUN : ST_DONE;
                end
            end
            ST_RUN: begin
                if (nand_ready) begin
                    if (!r_q.we) begin
                        r_d.rdata = rd_next;
                    end
                    if ({1'b0, r_q.idx} == r_q.beats - CNT_W'(1)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready  = (r_q.st == ST_DONE);
    assign cpu_rdata  = r_q.rdata;
    assign nand_valid = (r_q.st == ST_RUN);
    assign nand_we    = r_q.we;
    assign nand_cle   = nand_valid && (r_q.port == PORT_CMD);
    assign nand_ale   = nand_valid && (r_q.port == PORT_ADDR);
    assign nand_wdata = beat_wdata;

    // R9: an offered beat is held until accepted
    a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        nand_valid && !nand_ready |=> nand_valid && $stable(nand_wdata) &&
        $stable(nand_cle) && $stable(nand_ale) && $stable(nand_we));

    // R10: completion is a single-cycle pulse
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R6: the command strobe only ever accompanies a write beat
    a_r6_cle_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        nand_cle |-> nand_we && nand_valid);

    // R6: strobes never together
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R7: a completion without any beat returns zero
    a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !$past(nand_valid) |-> cpu_rdata == '0);

    // R10: completion follows the final beat or the accept cycle directly
    a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> $past(nand_valid && nand_ready) || !$past(nand_valid));
endmodule

// File: tb/nand_width_adapter_tb_top.sv
`timescale 1ns/1ps
module nand_width_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [1:0]  cpu_port = 2'd0;
    logic [1:0]  cpu_size = 2'd0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        cfg_is_nand = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        nand_valid;
    logic        nand_ready = 1'b0;
    logic        nand_we, nand_cle, nand_ale;
    logic [15:0] nand_wdata;
    logic [15:0] nand_rdata = '0;

    always #2 clk = ~clk;

    nand_width_adapter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_port(cpu_port), .cpu_size(cpu_size),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .cfg_is_nand(cfg_is_nand), .cfg_wide(cfg_wide),
        .nand_valid(nand_valid), .nand_ready(nand_ready), .nand_we(nand_we),
        .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_wdata(nand_wdata), .nand_rdata(nand_rdata)
    );

    typedef struct {
        logic [15:0] d;
        bit          cle;
        bit          ale;
        bit          we;
        int          idx;
    } beat_t;

    beat_t       expq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          last_hs = -10;
    int          acc_cyc = 0;
    bit          cur_active = 0;
    bit          cur_wide = 0;
    bit          fast = 0;
    logic [1:0]  cur_size = 0;
    string       cur_tag = "R1";
    logic [31:0] exp_rd = '0;
    logic [7:0]  lfsr = 8'hA5;
    logic [7:0]  rd_cnt = 8'h10;
    bit          done_run = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // reference device and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            lfsr       = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            nand_ready = fast ? 1'b1 : (lfsr[0] | lfsr[1]);
            rd_cnt     = rd_cnt + 8'd1;
            nand_rdata = {rd_cnt ^ 8'h5A, rd_cnt};
            if (!nand_valid) begin
                chk(!nand_cle && !nand_ale, "R6", {30'd0, nand_cle, nand_ale}, 32'd0, "strobe without beat");
            end else if (expq.size() == 0) begin
                chk(1'b0, cur_tag, 32'd1, 32'd0, "unexpected beat");
            end else begin
                beat_t h;
                string t;
                h = expq[0];
                t = nand_ready ? cur_tag : "R9";
                chk(nand_we == h.we, t, {31'd0, nand_we}, {31'd0, h.we}, "beat direction");
                chk(nand_cle == h.cle && nand_ale == h.ale, "R6",
                    {30'd0, nand_cle, nand_ale}, {30'd0, h.cle, h.ale}, "beat strobes");
                if (h.we) begin
                    chk(nand_wdata == h.d, t, {16'd0, nand_wdata}, {16'd0, h.d}, "beat data");
                end
                if (nand_ready) begin
                    if (!h.we) begin
                        if (cur_wide) begin
                            if (cur_size == 2'd0) exp_rd[7:0] = nand_rdata[7:0];
                            else exp_rd[h.idx*16 +: 16] = nand_rdata;
                        end else begin
                            exp_rd[h.idx*8 +: 8] = nand_rdata[7:0];
                        end
                    end
                    void'(expq.pop_front());
                    last_hs = cyc;
                end
            end
            if (cpu_ready) begin
                chk(cpu_rdata == exp_rd, cur_tag, cpu_rdata, exp_rd, "read data");
                chk(expq.size() == 0, cur_tag, expq.size(), 32'd0, "beats missing");
                if (cur_active) begin
                    chk(last_hs == cyc - 1, "R10", cyc - last_hs, 32'd1, "ready after last beat");
                end else begin
                    chk(cyc == acc_cyc + 1, "R7", cyc - acc_cyc, 32'd1, "ready after accept");
                end
            end
        end
    end

    task automatic txn(input string tag, input logic [1:0] port, input logic [1:0] size,
                       input bit we, input logic [31:0] wd, input bit isn, input bit wide,
                       input bit flip, input bit fst);
        int nb;
        int nbeat;
        int guard;
        @(negedge clk);
        cfg_is_nand = isn; cfg_wide = wide; fast = fst;
        cpu_port = port; cpu_size = size; cpu_we = we; cpu_wdata = wd; cpu_req = 1'b1;
        cur_tag = tag; cur_size = size; cur_wide = wide; exp_rd = '0; acc_cyc = cyc;
        nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        cur_active = isn && (port == 2'd2 || (we && port < 2'd2));
        if (cur_active) begin
            nbeat = wide ? ((nb == 4) ? 2 : 1) : nb;
            for (int i = 0; i < nbeat; i++) begin
                beat_t b;
                b.d   = wide ? wd[i*16 +: 16] : {8'h00, wd[i*8 +: 8]};
                b.cle = (port == 2'd0);
                b.ale = (port == 2'd1);
                b.we  = we;
                b.idx = i;
                expq.push_back(b);
            end
        end
        guard = 0;
        forever begin
            @(negedge clk);
            if (flip && guard == 0) cfg_wide = ~wide;
            if (cpu_ready) break;
            guard++;
            if (guard > 300) begin
                chk(1'b0, tag, 32'd0, 32'd1, "access hung");
                break;
            end
        end
        cpu_req = 1'b0;
        cfg_wide = wide;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !nand_valid && cpu_rdata == '0, "R10",
            {cpu_rdata[29:0], cpu_ready, nand_valid}, 32'd0, "reset state");
        // R1: 8-bit writes, byte order
        txn("R1", 2'd2, 2'd0, 1, 32'h1122_3344, 1, 0, 0, 0);
        txn("R1", 2'd2, 2'd1, 1, 32'hAABB_CCDD, 1, 0, 0, 0);
        txn("R1", 2'd2, 2'd2, 1, 32'hDEAD_BEEF, 1, 0, 0, 1);
        // R2: 16-bit writes
        txn("R2", 2'd2, 2'd1, 1, 32'h5566_7788, 1, 1, 0, 0);
        txn("R2", 2'd2, 2'd2, 1, 32'hCAFE_F00D, 1, 1, 0, 0);
        // R4: byte write to 16-bit device
        txn("R4", 2'd2, 2'd0, 1, 32'h0000_9A5C, 1, 1, 0, 0);
        // R5: reads assembled into lanes
        txn("R5", 2'd2, 2'd0, 0, 32'h0, 1, 0, 0, 0);
        txn("R5", 2'd2, 2'd1, 0, 32'h0, 1, 0, 0, 0);
        txn("R5", 2'd2, 2'd2, 0, 32'h0, 1, 0, 0, 1);
        txn("R5", 2'd2, 2'd1, 0, 32'h0, 1, 1, 0, 0);
        txn("R5", 2'd2, 2'd2, 0, 32'h0, 1, 1, 0, 0);
        // R3: byte read from 16-bit device
        txn("R3", 2'd2, 2'd0, 0, 32'h0, 1, 1, 0, 0);
        txn("R3", 2'd2, 2'd0, 0, 32'h0, 1, 1, 0, 1);
        // R6: command and address strobes
        txn("R6", 2'd0, 2'd0, 1, 32'h0000_0070, 1, 0, 0, 0);
        txn("R6", 2'd1, 2'd2, 1, 32'h0403_0201, 1, 0, 0, 0);
        txn("R6", 2'd1, 2'd1, 1, 32'h0000_BEEF, 1, 1, 0, 0);
        txn("R6", 2'd0, 2'd2, 1, 32'h1234_5678, 1, 1, 0, 0);
        // R7: ignored accesses
        txn("R7", 2'd2, 2'd2, 0, 32'h0, 0, 0, 0, 0);
        txn("R7", 2'd2, 2'd2, 1, 32'hFFFF_FFFF, 0, 1, 0, 0);
        txn("R7", 2'd0, 2'd2, 0, 32'h0, 1, 0, 0, 0);
        txn("R7", 2'd1, 2'd0, 0, 32'h0, 1, 1, 0, 0);
        txn("R7", 2'd3, 2'd2, 1, 32'h0BAD_0BAD, 1, 0, 0, 0);
        // R8: size code 3 acts as a word
        txn("R8", 2'd2, 2'd3, 1, 32'h8765_4321, 1, 0, 0, 0);
        txn("R8", 2'd2, 2'd3, 0, 32'h0, 1, 1, 0, 0);
        // R10: width change after acceptance ignored
        txn("R10", 2'd2, 2'd2, 1, 32'hA1B2_C3D4, 1, 0, 1, 0);
        txn("R10", 2'd2, 2'd2, 0, 32'h0, 1, 1, 1, 0);
        // R9: long stalls on mixed traffic
        for (int k = 0; k < 12; k++) begin
            txn("R9", 2'(k % 3), 2'(k % 4), (k % 3) != 2 || k[0], 32'h1357_9BDF + 32'(k * 7919),
                1, k[1], 0, 0);
        end
        repeat (3) @(negedge clk);
        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule